// File: doc/BRIEF.md
# Selectable Cache Replacement Policy Unit

This block keeps the replacement bookkeeping for every set of a set-associative cache with `NUM_WAYS` ways and `NUM_SETS` sets, and names the way to evict when the cache misses. A mode input picks one of three policies. The first is exact least-recently-used ordering. The second is a binary-tree approximation of that ordering. The third is a one-bit-per-line "not recently used" scheme. The block holds no tags and no data. The surrounding cache reports hits and misses, and the block answers with a way number.

Each cycle the cache presents a set index. A hit is reported with the access strobe and the way that hit. A miss is reported with the miss strobe. The victim for the addressed set is shown combinationally in the same cycle. On the next rising clock edge the set's state is updated as though the victim had been accessed. The policy is fixed for the whole time between resets.

Top module: `repl_policy_unit`

## Requirements
- R1: After reset, every set in every mode reports way 0 as its victim. LRU recency starts with way 0 oldest and way `NUM_WAYS-1` newest. All tree node bits start at 0, and all recently-used bits start at 0.
- R2: The mode input is captured only while `rstN` is low, using the encoding 0 = exact LRU, 1 = tree, 2 = recently-used bit, and 3 = exact LRU. Changes to the mode after reset is released have no effect until the next reset.
- R3: While `missEn` is high, `victimValid` is high and `victimWay` shows the victim of the set at `setIdx` in that same cycle. On the following edge, that set's state is updated exactly as an access to the victim would update it. `victimValid` is low whenever `missEn` is low.
- R4: If `missEn` and `accessEn` are high in the same cycle, the miss wins. `accessWay` is ignored, and only the victim is recorded as touched.
- R5: In exact LRU mode, the victim is the way touched longest ago in that set.
- R6: In tree mode, each set holds `NUM_WAYS-1` node bits. A node bit of 0 means the lower-numbered half below that node is older. The victim is found by walking from the root toward the older half at each node.
- R7: In tree mode, a touch sets every node bit on the touched way's path so that the bit points to the half not containing that way.
- R8: In recently-used-bit mode, a touch sets the touched way's bit. If that would leave every bit of the set at 1, all other bits of the set are cleared and only the touched way's bit stays 1.
- R9: In recently-used-bit mode, the victim is the lowest-numbered way whose bit is 0.
- R10: A hit or miss changes only the state of the set at `setIdx`. No other set changes.
- R11: A way touched in one cycle is never the victim of a miss to the same set in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low; the mode is sampled while low |
| modeSel | input | 2 | Policy select (0 LRU, 1 tree, 2 recently-used bit, 3 LRU) |
| setIdx | input | $clog2(NUM_SETS) | Set addressed this cycle |
| accessEn | input | 1 | Hit strobe |
| accessWay | input | $clog2(NUM_WAYS) | Way that hit |
| missEn | input | 1 | Miss strobe |
| victimWay | output | $clog2(NUM_WAYS) | Victim way of the addressed set |
| victimValid | output | 1 | High while a miss is being answered |

## Verification
The checker watches several properties on every cycle. It confirms that `victimValid` follows the miss strobe and that the captured mode never moves outside reset. It confirms that every set answers way 0 straight after reset. It also confirms that a way touched in one cycle is not named as the victim of the same set in the next cycle, which covers all three policies and the miss-over-hit priority. The exact eviction orders cannot be expressed as short properties. These are the full recency order, the tree walk, and the bit clearing when every bit is set. The bench's scenarios show them by driving hand-worked hit and miss sequences and comparing the victims. The same holds for the isolation between sets and for the mode-3 alias.

// File: rtl/repl_pkg.sv
package repl_pkg;

  typedef enum logic [1:0] {
    POL_LRU     = 2'd0,
    POL_TREE    = 2'd1,
    POL_BIT     = 2'd2,
    POL_LRU_ALT = 2'd3
  } policy_e;

  // strobes from control to the state datapath
  typedef struct packed {
    logic lruWr;
    logic treeWr;
    logic bitWr;
    logic useVictim;
  } stateCtrl_t;

endpackage

// File: rtl/repl_ctrl.sv
module repl_ctrl
  import repl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       accessEn,
  input  logic       missEn,
  output policy_e    modeQ,
  output stateCtrl_t ctl,
  output logic       victimValid
);

  logic touch;

  // mode register loads only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= policy_e'(modeSel);
  end

  assign touch = rstN & (missEn | accessEn);

  always_comb begin
    ctl           = '0;
    ctl.useVictim = missEn;
    unique case (modeQ)
      POL_TREE: ctl.treeWr = touch;
      POL_BIT:  ctl.bitWr  = touch;
      default:  ctl.lruWr  = touch;
    endcase
  end

  assign victimValid = rstN & missEn;

endmodule

// File: rtl/repl_state.sv
module repl_state
  import repl_pkg::*;
#(
  parameter  int NUM_WAYS = 4,
  parameter  int NUM_SETS = 8,
  localparam int WAY_W    = $clog2(NUM_WAYS),
  localparam int SET_W    = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  policy_e          modeQ,
  input  stateCtrl_t       ctl,
  input  logic [SET_W-1:0] setIdx,
  input  logic [WAY_W-1:0] accessWay,
  output logic [WAY_W-1:0] victimWay
);

  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(NUM_WAYS - 1);

  // per-set storage for all three policies
  logic [NUM_WAYS-1:0][WAY_W-1:0] ageQ  [NUM_SETS];
  logic [NUM_WAYS-1:0]            treeQ [NUM_SETS];  // node n at bit n, bit 0 spare
  logic [NUM_WAYS-1:0]            mruQ  [NUM_SETS];

  logic [NUM_WAYS-1:0][WAY_W-1:0] ageCur, ageNext;
  logic [NUM_WAYS-1:0]            treeCur, treeNext;
  logic [NUM_WAYS-1:0]            mruCur, mruNext, mruSet, mruOr, oldHot;
  logic [WAY_W-1:0]               lruVictim, treeVictim, bitVictim, touchWay;

  assign ageCur  = ageQ[setIdx];
  assign treeCur = treeQ[setIdx];
  assign mruCur  = mruQ[setIdx];

  assign touchWay = ctl.useVictim ? victimWay : accessWay;

  // exact LRU: age 0 is newest, NUM_WAYS-1 is oldest
  genvar w;
  generate
    for (w = 0; w < NUM_WAYS; w++) begin : g_way
      assign oldHot[w]  = (ageCur[w] == OLDEST);
      assign ageNext[w] = (WAY_W'(w) == touchWay)            ? '0 :
                          (ageCur[w] < ageCur[touchWay])     ? ageCur[w] + 1'b1 :
                                                               ageCur[w];
    end
  endgenerate

  always_comb begin
    lruVictim = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (oldHot[i]) lruVictim = WAY_W'(i);
    end
  end

  // tree: walk from root, bit 0 -> lower half older
  always_comb begin
    int node;
    node = 1;
    for (int l = 0; l < WAY_W; l++) begin
      node = 2 * node + int'(treeCur[WAY_W'(node)]);
    end
    treeVictim = WAY_W'(node - NUM_WAYS);
  end

  always_comb begin
    int pos;
    int nodeI;
    int dirI;
    treeNext = treeCur;
    pos      = NUM_WAYS + int'(touchWay);
    for (int l = 0; l < WAY_W; l++) begin
      nodeI = pos >> (WAY_W - l);
      dirI  = (pos >> (WAY_W - l - 1)) & 1;
      treeNext[WAY_W'(nodeI)] = (dirI == 0);
    end
  end

  // recently-used bit: lowest clear bit is the victim
  always_comb begin
    bitVictim = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (!mruCur[i]) bitVictim = WAY_W'(i);
    end
  end

  assign mruSet  = NUM_WAYS'(1) << touchWay;
  assign mruOr   = mruCur | mruSet;
  assign mruNext = (&mruOr) ? mruSet : mruOr;

  always_comb begin
    unique case (modeQ)
      POL_TREE: victimWay = treeVictim;
      POL_BIT:  victimWay = bitVictim;
      default:  victimWay = lruVictim;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int k = 0; k < NUM_WAYS; k++) begin
          ageQ[s][k] <= WAY_W'(NUM_WAYS - 1 - k);
        end
        treeQ[s] <= '0;
        mruQ[s]  <= '0;
      end
    end else begin
      if (ctl.lruWr)  ageQ[setIdx]  <= ageNext;
      if (ctl.treeWr) treeQ[setIdx] <= treeNext;
      if (ctl.bitWr)  mruQ[setIdx]  <= mruNext;
    end
  end

endmodule

// File: rtl/repl_policy_unit.sv
module repl_policy_unit
  import repl_pkg::*;
#(
  parameter  int NUM_WAYS = 4,
  parameter  int NUM_SETS = 8,
  localparam int WAY_W    = $clog2(NUM_WAYS),
  localparam int SET_W    = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic [SET_W-1:0] setIdx,
  input  logic             accessEn,
  input  logic [WAY_W-1:0] accessWay,
  input  logic             missEn,
  output logic [WAY_W-1:0] victimWay,
  output logic             victimValid
);

  policy_e    modeQ;
  stateCtrl_t ctl;

  repl_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .modeSel     (modeSel),
    .accessEn    (accessEn),
    .missEn      (missEn),
    .modeQ       (modeQ),
    .ctl         (ctl),
    .victimValid (victimValid)
  );

  repl_state #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_SETS (NUM_SETS)
  ) state_i (
    .clk       (clk),
    .rstN      (rstN),
    .modeQ     (modeQ),
    .ctl       (ctl),
    .setIdx    (setIdx),
    .accessWay (accessWay),
    .victimWay (victimWay)
  );

endmodule

// File: rtl/repl_policy_chk.sv
module repl_policy_chk #(
  parameter  int NUM_WAYS = 4,
  parameter  int NUM_SETS = 8,
  localparam int WAY_W    = $clog2(NUM_WAYS),
  localparam int SET_W    = $clog2(NUM_SETS)
) (
  input logic             clk,
  input logic             rstN,
  input logic [SET_W-1:0] setIdx,
  input logic             accessEn,
  input logic [WAY_W-1:0] accessWay,
  input logic             missEn,
  input logic [WAY_W-1:0] victimWay,
  input logic             victimValid,
  input logic [1:0]       modeQ
);

  // R3
  valid_follows_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid == missEn);

  // R2
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(modeQ));

  // R1
  reset_victim_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(rstN) && missEn) |-> (victimWay == '0));

  // R11 (with R4 choosing the touched way)
  fresh_way_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missEn || accessEn) |=>
      (!(missEn && setIdx == $past(setIdx)) ||
       victimWay != $past(missEn ? victimWay : accessWay)));

endmodule

bind repl_policy_unit repl_policy_chk #(
  .NUM_WAYS (NUM_WAYS),
  .NUM_SETS (NUM_SETS)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .setIdx      (setIdx),
  .accessEn    (accessEn),
  .accessWay   (accessWay),
  .missEn      (missEn),
  .victimWay   (victimWay),
  .victimValid (victimValid),
  .modeQ       (modeQ)
);

// File: tb/repl_policy_unit_tb.sv
module repl_policy_unit_tb_top;

  localparam int NW = 4;
  localparam int NS = 8;
  localparam int WW = $clog2(NW);
  localparam int SW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    modeSel = 2'd0;
  logic [SW-1:0] setIdx = '0;
  logic          accessEn = 1'b0;
  logic [WW-1:0] accessWay = '0;
  logic          missEn = 1'b0;
  logic [WW-1:0] victimWay;
  logic          victimValid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  repl_policy_unit #(.NUM_WAYS(NW), .NUM_SETS(NS)) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .modeSel     (modeSel),
    .setIdx      (setIdx),
    .accessEn    (accessEn),
    .accessWay   (accessWay),
    .missEn      (missEn),
    .victimWay   (victimWay),
    .victimValid (victimValid)
  );

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic applyReset(input int m);
    @(negedge clk);
    rstN = 1'b0; modeSel = 2'(m); accessEn = 1'b0; missEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic hitWay(input int s, input int w);
    @(negedge clk);
    setIdx = SW'(s); accessWay = WW'(w); accessEn = 1'b1; missEn = 1'b0;
    @(posedge clk); #1;
    accessEn = 1'b0;
  endtask

  task automatic missOn(input int s, output int v, output int vld);
    @(negedge clk);
    setIdx = SW'(s); missEn = 1'b1; accessEn = 1'b0;
    #2; v = int'(victimWay); vld = int'(victimValid);
    @(posedge clk); #1;
    missEn = 1'b0;
  endtask

  task automatic peekSet(input int s, output int v, output int vld);
    @(negedge clk);
    setIdx = SW'(s); missEn = 1'b0; accessEn = 1'b0;
    #2; v = int'(victimWay); vld = int'(victimValid);
  endtask

  task automatic testReset();
    int v, vld;
    for (int m = 0; m < 3; m++) begin
      applyReset(m);
      for (int s = 0; s < NS; s += 3) begin
        peekSet(s, v, vld);
        checkEq("R1 reset victim", v, 0);
        checkEq("R3 valid low without miss", vld, 0);
      end
    end
  endtask

  task automatic testLru();
    int v, vld;
    applyReset(0);
    hitWay(2, 2); hitWay(2, 0); hitWay(2, 3);
    peekSet(2, v, vld); checkEq("R5 lru oldest", v, 1);
    hitWay(2, 1);
    peekSet(2, v, vld); checkEq("R5 lru oldest after hit", v, 2);
    missOn(2, v, vld); checkEq("R3 miss victim", v, 2); checkEq("R3 valid on miss", vld, 1);
    missOn(2, v, vld); checkEq("R3 miss updates as access", v, 0);
    missOn(2, v, vld); checkEq("R5 miss chain", v, 3);
    missOn(2, v, vld); checkEq("R5 miss chain end", v, 1);
  endtask

  task automatic testTree();
    int v, vld;
    applyReset(1);
    missOn(5, v, vld); checkEq("R6 tree first", v, 0);
    missOn(5, v, vld); checkEq("R7 tree flip", v, 2);
    missOn(5, v, vld); checkEq("R7 tree flip", v, 1);
    missOn(5, v, vld); checkEq("R7 tree flip", v, 3);
    missOn(5, v, vld); checkEq("R6 tree wrap", v, 0);
    hitWay(4, 0);
    peekSet(4, v, vld); checkEq("R7 tree after hit", v, 2);
    hitWay(4, 3);
    peekSet(4, v, vld); checkEq("R6 tree walk", v, 1);
  endtask

  task automatic testBit();
    int v, vld;
    applyReset(2);
    hitWay(1, 0);
    peekSet(1, v, vld); checkEq("R9 bit lowest zero", v, 1);
    hitWay(1, 2);
    peekSet(1, v, vld); checkEq("R9 bit lowest zero", v, 1);
    hitWay(1, 1);
    peekSet(1, v, vld); checkEq("R9 bit lowest zero", v, 3);
    hitWay(1, 3);
    peekSet(1, v, vld); checkEq("R8 bit clear on full", v, 0);
    missOn(1, v, vld); checkEq("R8 bit miss", v, 0);
    peekSet(1, v, vld); checkEq("R8 bit after miss", v, 1);
    hitWay(0, 2); hitWay(0, 3); hitWay(0, 0); hitWay(0, 1);
    peekSet(0, v, vld); checkEq("R8 bit full keeps only touched", v, 0);
  endtask

  task automatic testModeHold();
    int v, vld;
    applyReset(1);
    @(negedge clk); modeSel = 2'd2;
    hitWay(3, 0);
    peekSet(3, v, vld); checkEq("R2 mode change ignored", v, 2);
    applyReset(3);
    hitWay(0, 2); hitWay(0, 3); hitWay(0, 0); hitWay(0, 1);
    peekSet(0, v, vld); checkEq("R2 mode 3 is lru", v, 2);
  endtask

  task automatic testPriority();
    int v, vld;
    applyReset(0);
    @(negedge clk);
    setIdx = SW'(4); missEn = 1'b1; accessEn = 1'b1; accessWay = WW'(3);
    #2; v = int'(victimWay); vld = int'(victimValid);
    checkEq("R4 miss wins victim", v, 0);
    checkEq("R4 miss wins valid", vld, 1);
    @(posedge clk); #1; missEn = 1'b0; accessEn = 1'b0;
    peekSet(4, v, vld); checkEq("R4 access way ignored", v, 1);
  endtask

  task automatic testSets();
    int v, vld;
    applyReset(0);
    hitWay(6, 0); hitWay(6, 1);
    peekSet(6, v, vld); checkEq("R10 touched set", v, 2);
    peekSet(7, v, vld); checkEq("R10 other set untouched", v, 0);
    peekSet(5, v, vld); checkEq("R10 other set untouched", v, 0);
  endtask

  initial begin
    testReset();
    testLru();
    testTree();
    testBit();
    testModeHold();
    testPriority();
    testSets();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule